// File: doc/BRIEF.md
# Quad Digital Potentiometer Command Engine

This block sits behind a two-wire serial slave front end and carries out the register-level command set for four potentiometer channels. Each channel owns one volatile 8-bit wiper code and four 8-bit stored settings, all held in flops. The front end hands over the instruction byte, an optional data byte, and START and STOP events. The engine decodes the instruction, returns read data, and commits writes and transfers when STOP arrives. It can also step a wiper up or down one tap at a time.

Every change to a stored setting counts as a slow nonvolatile store. Such a store raises a busy flag for a parameterised number of clocks, and a write-protect input can veto it. After reset each wiper reloads from stored slot 0 of its channel. Each channel drives its wiper code and a one-hot tap-select vector.

Top module: `qpot_cmd_engine`

## Requirements
- R1: After reset, each channel c holds stored slots r = 0..3 equal to DR_SEED + 16*c + r. The first clock after reset copies slot 0 into every wiper, and busy is low.
- R2: The instruction byte carries the opcode in bits [7:4], the stored-slot index in bits [3:2] and the channel index in bits [1:0].
- R3: Opcode 1010 followed by a data byte loads that byte into the addressed wiper when STOP arrives. If START comes in before STOP, nothing changes.
- R4: Opcode 1001 puts the addressed wiper on rd_data and opcode 1011 puts the addressed stored slot there. Either value is valid from the cycle after the instruction byte is accepted.
- R5: Opcode 1100 followed by a data byte stores that byte into the addressed slot at STOP while wp_n is high.
- R6: Opcode 1101 copies the addressed slot into the channel's wiper. Opcode 1110 copies the wiper into the addressed slot. Both are two-byte commands that take effect at STOP.
- R7: Opcode 0001 loads every wiper from slot r of its own channel. Opcode 1000 stores every wiper into slot r of its own channel.
- R8: Any command that changes a stored slot raises busy in the cycle after STOP and holds it for exactly BUSY_CYCLES cycles. While busy is high, instruction bytes are ignored and no wiper changes.
- R9: While wp_n is low, opcodes 1100, 1110 and 1000 leave every stored slot unchanged and do not raise busy.
- R10: After opcode 0010, each step_evt pulse moves the addressed wiper by one code, up when step_up is 1 and down when it is 0. The wiper saturates at 00h and FFh.
- R11: For each channel c, tap_sel bit c*256+code is the only bit set in that channel's 256-bit slice, where code is the channel's wiper code.
- R12: Opcodes 0000, 0011 to 0111 and 1111 change no register and do not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt | input | 1 | One-cycle pulse: bus START seen |
| cmd_valid | input | 1 | One-cycle pulse: instruction byte received |
| cmd_byte | input | 8 | Instruction byte |
| data_valid | input | 1 | One-cycle pulse: data byte received |
| data_byte | input | 8 | Data byte |
| stop_evt | input | 1 | One-cycle pulse: bus STOP seen |
| step_evt | input | 1 | One-cycle pulse: one step clock in step mode |
| step_up | input | 1 | Step direction, 1 = toward the high terminal |
| wp_n | input | 1 | Write-protect, low blocks stores |
| rd_data | output | 8 | Read data for the latched instruction |
| busy | output | 1 | Store in progress |
| wiper_code | output | 32 | Four wiper codes, channel c in bits [8c+7:8c] |
| tap_sel | output | 1024 | Four one-hot tap selects, channel c in bits [256c+255:256c] |

## Verification
Every result comes from a single register stage. A wiper, a stored slot or busy changes on the clock edge that samples STOP or a step pulse, and read data becomes valid on the edge that samples the instruction byte. The bench therefore drives each pulse for one cycle from a falling edge and samples on the next falling edge. Busy is checked at that same sample, again BUSY_CYCLES-1 cycles later, and once more one cycle after that to catch its fall. Stored slots are read back through the read opcode, not probed.

// File: rtl/qpot_pkg.sv
package qpot_pkg;
   typedef enum logic [3:0] {
      OP_GXIN  = 4'b0001,
      OP_STEP  = 4'b0010,
      OP_GXOUT = 4'b1000,
      OP_RDW   = 4'b1001,
      OP_WRW   = 4'b1010,
      OP_RDD   = 4'b1011,
      OP_WRD   = 4'b1100,
      OP_XIN   = 4'b1101,
      OP_XOUT  = 4'b1110
   } qpot_op_e;

   typedef struct packed {
      logic rd_wiper;
      logic wr_wiper;
      logic wr_data;
      logic xfr_in;
      logic xfr_out;
      logic global;
      logic step;
      logic store;
   } qpot_dec_t;
endpackage

// File: rtl/qpot_decode.sv
module qpot_decode
   import qpot_pkg::*;
(
   input  logic [3:0] op_i,
   output qpot_dec_t  dec_o
);
   always_comb begin
      dec_o = '0;
      case (op_i)
         OP_RDW:   dec_o.rd_wiper = 1'b1;
         OP_WRW:   dec_o.wr_wiper = 1'b1;
         OP_WRD:   begin dec_o.wr_data = 1'b1; dec_o.store = 1'b1; end
         OP_XIN:   dec_o.xfr_in = 1'b1;
         OP_XOUT:  begin dec_o.xfr_out = 1'b1; dec_o.store = 1'b1; end
         OP_GXIN:  begin dec_o.xfr_in = 1'b1; dec_o.global = 1'b1; end
         OP_GXOUT: begin dec_o.xfr_out = 1'b1; dec_o.global = 1'b1; dec_o.store = 1'b1; end
         OP_STEP:  dec_o.step = 1'b1;
         default:  dec_o = '0;
      endcase
   end
endmodule

// File: rtl/qpot_busy.sv
module qpot_busy #(
   parameter int CYC = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CNTW = $clog2(CYC + 1);

   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("qpot_busy: CYC must be at least 1");
      end
   endgenerate

   logic [CNTW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (start_i)          cnt_q <= CNTW'(CYC);
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/qpot_chan.sv
module qpot_chan #(
   parameter int          W         = 8,
   parameter int          NREG      = 4,
   parameter int          RW        = 2,
   parameter logic [W-1:0] INIT_BASE = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               recall_i,
   input  logic               wr_wiper_i,
   input  logic               xfr_in_i,
   input  logic               xfr_out_i,
   input  logic               wr_data_i,
   input  logic               step_i,
   input  logic               step_up_i,
   input  logic [RW-1:0]      sel_i,
   input  logic [W-1:0]       dval_i,
   output logic [W-1:0]       wiper_o,
   output logic [NREG*W-1:0]  regs_o,
   output logic [(1<<W)-1:0]  tap_o
);
   localparam int TAPS = 1 << W;

   logic [W-1:0] wiper_q;
   logic [W-1:0] slot_q [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wiper_q <= '0;
      end else if (recall_i) begin
         wiper_q <= slot_q[0];
      end else if (wr_wiper_i) begin
         wiper_q <= dval_i;
      end else if (xfr_in_i) begin
         wiper_q <= slot_q[sel_i];
      end else if (step_i) begin
         if (step_up_i && (wiper_q != '1))      wiper_q <= wiper_q + 1'b1;
         else if (!step_up_i && (wiper_q != '0)) wiper_q <= wiper_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) slot_q[r] <= INIT_BASE + W'(r);
      end else if (wr_data_i) begin
         slot_q[sel_i] <= dval_i;
      end else if (xfr_out_i) begin
         slot_q[sel_i] <= wiper_q;
      end
   end

   assign wiper_o = wiper_q;

   for (genvar r = 0; r < NREG; r++) begin : g_regs
      assign regs_o[r*W +: W] = slot_q[r];
   end

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign tap_o[t] = (wiper_q == W'(t));
   end
endmodule

// File: rtl/qpot_cmd_engine.sv
module qpot_cmd_engine
   import qpot_pkg::*;
#(
   parameter int          NCH         = 4,
   parameter int          W           = 8,
   parameter int          NREG        = 4,
   parameter int          BUSY_CYCLES = 250000,
   parameter logic [7:0]  DR_SEED     = 8'h40
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_evt,
   input  logic                     cmd_valid,
   input  logic [W-1:0]             cmd_byte,
   input  logic                     data_valid,
   input  logic [W-1:0]             data_byte,
   input  logic                     stop_evt,
   input  logic                     step_evt,
   input  logic                     step_up,
   input  logic                     wp_n,
   output logic [W-1:0]             rd_data,
   output logic                     busy,
   output logic [NCH*W-1:0]         wiper_code,
   output logic [NCH*(1<<W)-1:0]    tap_sel
);
   localparam int CW   = $clog2(NCH);
   localparam int RW   = $clog2(NREG);
   localparam int TAPS = 1 << W;

   generate
      if ((1 << CW) != NCH || (1 << RW) != NREG) begin : g_bad_pow2
         $error("qpot_cmd_engine: NCH and NREG must be powers of two");
      end
      if (4 + RW + CW != W) begin : g_bad_layout
         $error("qpot_cmd_engine: opcode, slot and channel fields must fill the byte");
      end
   endgenerate

   logic [W-1:0] instr_q, dbyte_q;
   logic         have_cmd_q, have_data_q, recall_q;

   wire [3:0]    op   = instr_q[W-1 -: 4];
   wire [RW-1:0] rsel = instr_q[CW +: RW];
   wire [CW-1:0] csel = instr_q[CW-1:0];

   qpot_dec_t dec;
   qpot_decode u_dec (.op_i(op), .dec_o(dec));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         instr_q     <= '0;
         dbyte_q     <= '0;
         have_cmd_q  <= 1'b0;
         have_data_q <= 1'b0;
         recall_q    <= 1'b1;
      end else begin
         recall_q <= 1'b0;
         if (start_evt || stop_evt) begin
            have_cmd_q  <= 1'b0;
            have_data_q <= 1'b0;
         end else if (cmd_valid && !busy) begin
            instr_q     <= cmd_byte;
            have_cmd_q  <= 1'b1;
            have_data_q <= 1'b0;
         end else if (data_valid && have_cmd_q) begin
            dbyte_q     <= data_byte;
            have_data_q <= 1'b1;
         end
      end
   end

   wire exec     = stop_evt && have_cmd_q;
   wire do_wr_w  = exec && dec.wr_wiper && have_data_q;
   wire do_wr_d  = exec && dec.wr_data && have_data_q && wp_n;
   wire do_xin   = exec && dec.xfr_in;
   wire do_xout  = exec && dec.xfr_out && wp_n;
   wire do_step  = step_evt && have_cmd_q && dec.step && !start_evt && !stop_evt;
   wire do_store = exec && dec.store && wp_n && (!dec.wr_data || have_data_q);

   qpot_busy #(.CYC(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .start_i(do_store), .busy_o(busy)
   );

   logic [W-1:0]      wiper_a [NCH];
   logic [NREG*W-1:0] regs_a  [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      wire hit = dec.global || (csel == CW'(c));
      qpot_chan #(
         .W(W), .NREG(NREG), .RW(RW),
         .INIT_BASE(W'(DR_SEED + 16*c))
      ) u_chan (
         .clk(clk), .rst_n(rst_n),
         .recall_i(recall_q),
         .wr_wiper_i(do_wr_w && hit),
         .xfr_in_i(do_xin && hit),
         .xfr_out_i(do_xout && hit),
         .wr_data_i(do_wr_d && hit),
         .step_i(do_step && hit),
         .step_up_i(step_up),
         .sel_i(rsel),
         .dval_i(dbyte_q),
         .wiper_o(wiper_a[c]),
         .regs_o(regs_a[c]),
         .tap_o(tap_sel[c*TAPS +: TAPS])
      );
      assign wiper_code[c*W +: W] = wiper_a[c];
   end

   assign rd_data = dec.rd_wiper ? wiper_a[csel] : regs_a[csel][rsel*W +: W];
endmodule

// File: rtl/qpot_cmd_engine_chk.sv
module qpot_cmd_engine_chk #(
   parameter int NCH         = 4,
   parameter int W           = 8,
   parameter int BUSY_CYCLES = 250000
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  stop_evt,
   input logic                  wp_n,
   input logic                  busy,
   input logic [NCH*W-1:0]      wiper_code,
   input logic [NCH*(1<<W)-1:0] tap_sel
);
   localparam int TAPS = 1 << W;
   localparam int RUNW = $clog2(BUSY_CYCLES + 2);

   logic [RUNW-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_q <= '0;
      else if (busy)  run_q <= run_q + 1'b1;
      else            run_q <= '0;
   end

   // R8
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt));

   // R8
   busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(wiper_code));

   // R8
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < RUNW'(BUSY_CYCLES)));

   // R9
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && !wp_n && !busy) |=> !busy);

   for (genvar c = 0; c < NCH; c++) begin : g_tap_chk
      // R11
      tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(tap_sel[c*TAPS +: TAPS]) == 1);
      // R11
      tap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tap_sel[c*TAPS + int'(wiper_code[c*W +: W])]);
   end
endmodule

bind qpot_cmd_engine qpot_cmd_engine_chk #(
   .NCH(NCH), .W(W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .wp_n(wp_n),
   .busy(busy), .wiper_code(wiper_code), .tap_sel(tap_sel)
);

// File: tb/qpot_cmd_engine_bench.sv
module qpot_cmd_engine_bench;
   localparam int BUSY = 20;
   localparam int SEED = 8'h40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_evt = 0, cmd_valid = 0, data_valid = 0, stop_evt = 0;
   logic step_evt = 0, step_up = 0, wp_n = 1;
   logic [7:0] cmd_byte = '0, data_byte = '0;
   logic [7:0] rd_data;
   logic       busy;
   logic [31:0]   wiper_code;
   logic [1023:0] tap_sel;

   int nchk = 0, nerr = 0;
   int w [4];
   int d [4][4];

   always #2 clk = ~clk;

   qpot_cmd_engine #(.BUSY_CYCLES(BUSY), .DR_SEED(8'(SEED))) u_qpot_cmd_engine (
      .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .cmd_valid(cmd_valid),
      .cmd_byte(cmd_byte), .data_valid(data_valid), .data_byte(data_byte),
      .stop_evt(stop_evt), .step_evt(step_evt), .step_up(step_up), .wp_n(wp_n),
      .rd_data(rd_data), .busy(busy), .wiper_code(wiper_code), .tap_sel(tap_sel)
   );

   task automatic tick; @(posedge clk); @(negedge clk); endtask

   task automatic check(string req, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_wipers(string req);
      for (int c = 0; c < 4; c++) begin
         check(req, int'(wiper_code[c*8 +: 8]), w[c]);
         check({req, " R11"}, int'(tap_sel[c*256 + w[c]]) +
               16 * $countones(tap_sel[c*256 +: 256]), 17);
      end
   endtask

   task automatic send(int op, int r, int c, bit has_d, int dat, bit stp);
      start_evt = 1; tick; start_evt = 0;
      cmd_byte = 8'((op << 4) | (r << 2) | c); cmd_valid = 1; tick; cmd_valid = 0;
      if (has_d) begin data_byte = 8'(dat); data_valid = 1; tick; data_valid = 0; end
      if (stp) begin stop_evt = 1; tick; stop_evt = 0; end
   endtask

   task automatic stop_pulse; stop_evt = 1; tick; stop_evt = 0; endtask

   task automatic wait_idle;
      for (int i = 0; i < BUSY + 2 && busy; i++) tick;
   endtask

   task automatic read_dr(int c, int r, string req);
      send(4'b1011, r, c, 0, 0, 0);
      check(req, int'(rd_data), d[c][r]);
      stop_pulse;
   endtask

   initial begin
      #400000;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++) d[c][r] = SEED + 16*c + r;
      for (int c = 0; c < 4; c++) w[c] = d[c][0];
      repeat (3) tick;
      rst_n = 1; tick;
      // R1 recall of slot 0 and idle busy
      check_wipers("R1 recall");
      check("R1 busy", int'(busy), 0);
      // R4 R2 read every stored slot and every wiper
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++) read_dr(c, r, "R4 R2 slot read");
      for (int c = 0; c < 4; c++) begin
         send(4'b1001, 0, c, 0, 0, 0);
         check("R4 wiper read", int'(rd_data), w[c]);
         stop_pulse;
      end
      // R3 direct wiper writes
      for (int c = 0; c < 4; c++) begin
         w[c] = 8'h11 * (c + 3);
         send(4'b1010, 0, c, 1, w[c], 1);
      end
      check_wipers("R3 write");
      // R3 aborted by START before STOP
      send(4'b1010, 0, 1, 1, 8'h5A, 0);
      start_evt = 1; tick; start_evt = 0;
      stop_pulse;
      check_wipers("R3 abort");
      // R5 R8 store sweep with busy window on the first
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++) begin
            d[c][r] = (c*32 + r*5 + 7) & 255;
            send(4'b1100, r, c, 1, d[c][r], 1);
            if (c == 0 && r == 0) begin
               check("R8 busy rise", int'(busy), 1);
               send(4'b1010, 0, 0, 1, 8'hEE, 1);
               check_wipers("R8 ignored while busy");
               repeat (BUSY - 1 - 4) tick;
               check("R8 busy hold", int'(busy), 1);
               tick;
               check("R8 busy fall", int'(busy), 0);
            end
            wait_idle;
         end
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++) read_dr(c, r, "R5 stored");
      // R9 write protect
      wp_n = 0;
      send(4'b1100, 2, 3, 1, 8'h99, 1);
      check("R9 no busy", int'(busy), 0);
      send(4'b1110, 3, 1, 0, 0, 1);
      check("R9 no busy xfr", int'(busy), 0);
      send(4'b1000, 0, 0, 0, 0, 1);
      check("R9 no busy global", int'(busy), 0);
      wp_n = 1;
      read_dr(3, 2, "R9 slot kept");
      read_dr(1, 3, "R9 slot kept");
      read_dr(2, 0, "R9 slot kept");
      // R6 single-channel transfers
      send(4'b1101, 3, 2, 0, 0, 1);
      w[2] = d[2][3];
      check_wipers("R6 slot to wiper");
      send(4'b1110, 0, 1, 0, 0, 1);
      d[1][0] = w[1];
      check("R6 busy", int'(busy), 1);
      wait_idle;
      read_dr(1, 0, "R6 wiper to slot");
      // R7 global transfers
      send(4'b0001, 1, 0, 0, 0, 1);
      for (int c = 0; c < 4; c++) w[c] = d[c][1];
      check_wipers("R7 global load");
      for (int c = 0; c < 4; c++) begin
         w[c] = 8'h21 + 8'h30 * c;
         send(4'b1010, 0, c, 1, w[c], 1);
      end
      send(4'b1000, 2, 0, 0, 0, 1);
      for (int c = 0; c < 4; c++) d[c][2] = w[c];
      check("R7 busy", int'(busy), 1);
      wait_idle;
      for (int c = 0; c < 4; c++) read_dr(c, 2, "R7 global store");
      // R10 stepping with saturation
      w[0] = 8'hFD; send(4'b1010, 0, 0, 1, w[0], 1);
      w[3] = 8'h02; send(4'b1010, 0, 3, 1, w[3], 1);
      send(4'b0010, 0, 0, 0, 0, 0);
      step_up = 1;
      for (int i = 0; i < 4; i++) begin
         step_evt = 1; tick; step_evt = 0;
         w[0] = (w[0] < 255) ? w[0] + 1 : 255;
         check("R10 step up", int'(wiper_code[7:0]), w[0]);
      end
      stop_pulse;
      send(4'b0010, 0, 3, 0, 0, 0);
      step_up = 0;
      for (int i = 0; i < 4; i++) begin
         step_evt = 1; tick; step_evt = 0;
         w[3] = (w[3] > 0) ? w[3] - 1 : 0;
         check("R10 step down", int'(wiper_code[31:24]), w[3]);
      end
      stop_pulse;
      step_evt = 1; tick; step_evt = 0;
      check_wipers("R10 step after stop");
      // R12 unused opcode sweep
      for (int op = 0; op < 16; op++) begin
         if (op == 0 || (op >= 3 && op <= 7) || op == 15) begin
            send(op, 1, 2, 1, 8'hA5, 1);
            check("R12 no busy", int'(busy), 0);
         end
      end
      check_wipers("R12 wipers");
      read_dr(2, 1, "R12 slot");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule